// File: doc/BRIEF.md
# Record-Path Overload Flag and Startup Mute

This block sits at the end of a stereo record path, next to the serial output. It sees one signed left word and one signed right word per sample period, marked by a one-cycle strobe. A sample counts as a violation when either word's magnitude lies above a parameterised level just below full scale. The overload flag then rises and stays up for a fixed number of sample periods. Each new violation pushes the release back, so the flag works as a level indicator for setting record gain.

The block also gates the samples that go to the serial output. After reset, or after a restart pulse that marks a power-up or a clock restart, the gated words are held at zero. They stay at zero until the filter path has settled. The length of that window depends on the DC-cancellation enable: 1024 sample periods with the filter off and 12288 with it on.

Two state machines drive the behaviour. The hold timer has the states HOLD_IDLE and HOLD_ACTIVE:
- A violating strobe takes it from HOLD_IDLE to HOLD_ACTIVE. This transition is called *trip*.
- A violating strobe in HOLD_ACTIVE reloads the count. This transition is called *retrigger*.
- A quiet strobe that exhausts the count returns it to HOLD_IDLE. This transition is called *expire*.

The mute sequencer has the states MUTE_WAIT and MUTE_PASS:
- The strobe that completes the settling count takes it from MUTE_WAIT to MUTE_PASS. This transition is called *settle*.
- A restart sends both machines back to their first state from any state. This transition is called *rearm*.

Top module: `ovl_flag_monitor`

## Requirements
- R1: On a strobe, a sample word above +THRESH or below -THRESH (default THRESH = 458752 for 20-bit words) on either channel raises ovl_flag in the next cycle. A word equal to +THRESH or -THRESH does not raise the flag.
- R2: The most negative code (-2^19 for 20-bit words) is treated as a violation.
- R3: After the last violating strobe, ovl_flag stays high through the next 511 non-violating strobes. It goes low in the cycle after the 512th non-violating strobe.
- R4: A violating strobe while the flag is high reloads the full 512-strobe hold. The release is then counted from that newest violation.
- R5: With dcf_en low, out_left and out_right are zero for the first 1024 strobes after reset or restart. dcf_en must be stable over the window.
- R6: With dcf_en high, out_left and out_right are zero for the first 12288 strobes after reset or restart.
- R7: Once the mute window has ended, every strobe copies smp_left and smp_right to out_left and out_right in the next cycle. The outputs hold those values until the next strobe.
- R8: A restart pulse clears ovl_flag and the hold count, zeroes the outputs and restarts the mute window in the next cycle. This takes priority over a strobe in the same cycle.
- R9: Sample words presented while smp_stb is low change neither ovl_flag nor the outputs.
- R10: While in reset and in the first cycle after it, ovl_flag is low and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle strobe per sample period |
| smp_left | input | SAMPLE_W | Signed left sample word |
| smp_right | input | SAMPLE_W | Signed right sample word |
| dcf_en | input | 1 | DC-cancellation filter enabled; selects the mute length |
| restart | input | 1 | Power-up or clock-restart pulse |
| ovl_flag | output | 1 | Overload indicator |
| out_left | output | SAMPLE_W | Gated left word |
| out_right | output | SAMPLE_W | Gated right word |

## Verification
Every result is registered once, so the flag and both gated words change exactly one clock after the edge that captures a strobe or a restart. Counts such as the 512-strobe hold and the two mute windows are measured in strobes, not in clock cycles. The bench drives each strobe on a falling edge, lowers it on the next falling edge and compares there, one clock after the capturing edge. It keeps its own model of the hold count and the strobes since restart, and checks after every strobe. This places the release check exactly on the 512th quiet strobe, and the unmute checks exactly on strobes 1024/1025 and 12288/12289.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
    typedef enum logic {HOLD_IDLE, HOLD_ACTIVE} hold_state_t;
    typedef enum logic {MUTE_WAIT, MUTE_PASS} mute_state_t;
endpackage

// File: rtl/ovl_level_detect.sv
`timescale 1ns/1ps
module ovl_level_detect #(
    parameter int SAMPLE_W = 20,
    parameter int THRESH   = 458752
) (
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                over
);
    localparam logic signed [SAMPLE_W-1:0] POS_LIM = SAMPLE_W'(THRESH);
    localparam logic signed [SAMPLE_W-1:0] NEG_LIM = SAMPLE_W'(-THRESH);

    logic [SAMPLE_W-1:0] chan [2];
    logic [1:0]          hit;

    assign chan[0] = smp_left;
    assign chan[1] = smp_right;

    // the most negative code lies below NEG_LIM, so it trips as well
    for (genvar c = 0; c < 2; c++) begin : g_chan
        assign hit[c] = ($signed(chan[c]) > POS_LIM) || ($signed(chan[c]) < NEG_LIM);
    end

    assign over = |hit;
endmodule

// File: rtl/ovl_hold_timer.sv
`timescale 1ns/1ps
module ovl_hold_timer
    import ovl_pkg::*;
#(
    parameter int HOLD_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trip,
    input  logic restart,
    output logic flag
);
    localparam int CW = $clog2(HOLD_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_LEN);

    hold_state_t state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            HOLD_IDLE:   if (trip) nxt = HOLD_ACTIVE;
            HOLD_ACTIVE: if (tick && !trip && cnt == CW'(1)) nxt = HOLD_IDLE;
        endcase
        if (restart) nxt = HOLD_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HOLD_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (restart)                          cnt <= '0;
            else if (trip)                        cnt <= LOAD;
            else if (tick && state == HOLD_ACTIVE) cnt <= cnt - CW'(1);
        end
    end

    always_comb flag = (state == HOLD_ACTIVE);
endmodule

// File: rtl/ovl_mute_seq.sv
`timescale 1ns/1ps
module ovl_mute_seq
    import ovl_pkg::*;
#(
    parameter int SAMPLE_W     = 20,
    parameter int MUTE_OFF_LEN = 1024,
    parameter int MUTE_ON_LEN  = 12288
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                dcf_en,
    input  logic                restart,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    localparam int MAX_LEN = (MUTE_ON_LEN > MUTE_OFF_LEN) ? MUTE_ON_LEN : MUTE_OFF_LEN;
    localparam int CW      = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] LAST_OFF = CW'(MUTE_OFF_LEN - 1);
    localparam logic [CW-1:0] LAST_ON  = CW'(MUTE_ON_LEN - 1);

    mute_state_t state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = dcf_en ? LAST_ON : LAST_OFF;

    always_comb begin
        nxt = state;
        unique case (state)
            MUTE_WAIT: if (tick && cnt >= last) nxt = MUTE_PASS;
            MUTE_PASS: nxt = MUTE_PASS;
        endcase
        if (restart) nxt = MUTE_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MUTE_WAIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (restart)                         cnt <= '0;
            else if (tick && state == MUTE_WAIT) cnt <= cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_left  <= '0;
            out_right <= '0;
        end else if (restart) begin
            out_left  <= '0;
            out_right <= '0;
        end else if (tick) begin
            out_left  <= (state == MUTE_PASS) ? in_left  : '0;
            out_right <= (state == MUTE_PASS) ? in_right : '0;
        end
    end
endmodule

// File: rtl/ovl_flag_monitor.sv
`timescale 1ns/1ps
module ovl_flag_monitor #(
    parameter int SAMPLE_W     = 20,
    parameter int THRESH       = 458752,
    parameter int HOLD_LEN     = 512,
    parameter int MUTE_OFF_LEN = 1024,
    parameter int MUTE_ON_LEN  = 12288
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                dcf_en,
    input  logic                restart,
    output logic                ovl_flag,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    logic over;
    logic tick;
    logic trip;

    assign tick = smp_stb && !restart;
    assign trip = tick && over;

    ovl_level_detect #(.SAMPLE_W(SAMPLE_W), .THRESH(THRESH)) u_det (
        .smp_left (smp_left),
        .smp_right(smp_right),
        .over     (over)
    );

    ovl_hold_timer #(.HOLD_LEN(HOLD_LEN)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .trip   (trip),
        .restart(restart),
        .flag   (ovl_flag)
    );

    ovl_mute_seq #(
        .SAMPLE_W    (SAMPLE_W),
        .MUTE_OFF_LEN(MUTE_OFF_LEN),
        .MUTE_ON_LEN (MUTE_ON_LEN)
    ) u_mute (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .dcf_en   (dcf_en),
        .restart  (restart),
        .in_left  (smp_left),
        .in_right (smp_right),
        .out_left (out_left),
        .out_right(out_right)
    );
endmodule

// File: rtl/ovl_flag_monitor_chk.sv
`timescale 1ns/1ps
module ovl_flag_monitor_chk #(
    parameter int SAMPLE_W     = 20,
    parameter int THRESH       = 458752,
    parameter int HOLD_LEN     = 512,
    parameter int MUTE_OFF_LEN = 1024,
    parameter int MUTE_ON_LEN  = 12288
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_stb,
    input logic [SAMPLE_W-1:0] smp_left,
    input logic [SAMPLE_W-1:0] smp_right,
    input logic                dcf_en,
    input logic                restart,
    input logic                ovl_flag,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right
);
    localparam int MAX_LEN = (MUTE_ON_LEN > MUTE_OFF_LEN) ? MUTE_ON_LEN : MUTE_OFF_LEN;
    localparam int HW = $clog2(HOLD_LEN + 1);
    localparam int MW = $clog2(MAX_LEN + 2);
    localparam logic signed [SAMPLE_W-1:0] POS_LIM = SAMPLE_W'(THRESH);
    localparam logic signed [SAMPLE_W-1:0] NEG_LIM = SAMPLE_W'(-THRESH);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic          viol;
    logic [HW-1:0] quiet;
    logic [MW-1:0] seen;
    logic [MW-1:0] need;

    assign viol = ($signed(smp_left)  > POS_LIM) || ($signed(smp_left)  < NEG_LIM) ||
                  ($signed(smp_right) > POS_LIM) || ($signed(smp_right) < NEG_LIM);
    assign need = dcf_en ? MW'(MUTE_ON_LEN) : MW'(MUTE_OFF_LEN);

    // quiet strobes since last violation, saturating; seen = strobes since restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet <= HW'(HOLD_LEN);
            seen  <= '0;
        end else if (restart) begin
            quiet <= HW'(HOLD_LEN);
            seen  <= '0;
        end else if (smp_stb) begin
            if (viol)                        quiet <= '0;
            else if (quiet < HW'(HOLD_LEN)) quiet <= quiet + HW'(1);
            if (seen <= MW'(MAX_LEN))        seen  <= seen + MW'(1);
        end
    end

    a_r1_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !restart && viol) |=> ovl_flag);

    a_r2_most_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !restart && smp_left == MOST_NEG) |=> ovl_flag);

    a_r3_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_flag == (quiet < HW'(HOLD_LEN)));

    a_r5_muted_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_left != '0 || out_right != '0) |-> (seen > need));

    a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !restart && seen >= need) |=>
            (out_left == $past(smp_left) && out_right == $past(smp_right)));

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!ovl_flag && out_left == '0 && out_right == '0));

    a_r9_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_stb && !restart) |=> ($stable(out_left) && $stable(out_right) && !$rose(ovl_flag)));
endmodule

bind ovl_flag_monitor ovl_flag_monitor_chk #(
    .SAMPLE_W    (SAMPLE_W),
    .THRESH      (THRESH),
    .HOLD_LEN    (HOLD_LEN),
    .MUTE_OFF_LEN(MUTE_OFF_LEN),
    .MUTE_ON_LEN (MUTE_ON_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .smp_left (smp_left),
    .smp_right(smp_right),
    .dcf_en   (dcf_en),
    .restart  (restart),
    .ovl_flag (ovl_flag),
    .out_left (out_left),
    .out_right(out_right)
);

// File: tb/sim_ovl_flag_monitor.sv
`timescale 1ns/1ps
module sim_ovl_flag_monitor;
    localparam int W    = 20;
    localparam int THR  = 458752;
    localparam int HOLD = 512;
    localparam int MOFF = 1024;
    localparam int MON  = 12288;
    localparam int FULL = 1 << (W - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic [W-1:0] sl = '0;
    logic [W-1:0] sr = '0;
    logic dcf = 1'b0;
    logic rs = 1'b0;
    logic flag;
    logic [W-1:0] ol, orr;

    always #2.5 clk = ~clk;

    ovl_flag_monitor #(.SAMPLE_W(W), .THRESH(THR), .HOLD_LEN(HOLD),
                       .MUTE_OFF_LEN(MOFF), .MUTE_ON_LEN(MON)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(stb), .smp_left(sl), .smp_right(sr),
        .dcf_en(dcf), .restart(rs), .ovl_flag(flag), .out_left(ol), .out_right(orr));

    int checks = 0;
    int fails  = 0;
    int m_hold = 0;
    int m_k    = 0;
    logic [W-1:0] m_ol = '0, m_or = '0;

    function automatic bit is_over(logic [W-1:0] s);
        int v;
        v = int'($signed(s));
        return (v > THR) || (v < -THR);
    endfunction

    function automatic logic [W-1:0] rnd_small();
        int v;
        v = int'($urandom % (2 * THR + 1)) - THR;
        return W'(v);
    endfunction

    function automatic logic [W-1:0] rnd_big();
        int v;
        v = THR + 1 + int'($urandom % (FULL - THR - 1));
        if ($urandom % 2) v = -v - 1;
        return W'(v);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(string tag, logic [W-1:0] l, logic [W-1:0] r, int gap);
        @(negedge clk);
        stb = 1'b1; sl = l; sr = r;
        @(negedge clk);
        stb = 1'b0;
        if (is_over(l) || is_over(r)) m_hold = HOLD;
        else if (m_hold > 0) m_hold--;
        if (m_k <= MON) m_k++;
        if (m_k > (dcf ? MON : MOFF)) begin m_ol = l; m_or = r; end
        else begin m_ol = '0; m_or = '0; end
        check(tag, 64'(flag), 64'(m_hold > 0));
        check(tag, 64'({ol, orr}), 64'({m_ol, m_or}));
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_restart(logic new_dcf, logic with_stb, logic [W-1:0] l);
        @(negedge clk);
        rs = 1'b1; dcf = new_dcf; stb = with_stb; sl = l; sr = l;
        @(negedge clk);
        rs = 1'b0; stb = 1'b0;
        m_hold = 0; m_k = 0; m_ol = '0; m_or = '0;
        check("R8", 64'(flag), 64'd0);
        check("R8", 64'({ol, orr}), 64'd0);
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] hold_l, hold_r;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R10", 64'({flag, ol, orr}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", 64'({flag, ol, orr}), 64'd0);

        // R5: mute with filter off, then R7 pass-through
        do_restart(1'b0, 1'b0, '0);
        for (int i = 0; i < MOFF; i++) strobe("R5", rnd_small(), rnd_small(), 1);
        strobe("R7", W'(12345), W'(-777), 1);
        strobe("R7", rnd_small(), rnd_small(), 1);

        // R9: big words without a strobe change nothing
        hold_l = ol; hold_r = orr;
        @(negedge clk); sl = W'(-FULL); sr = W'(FULL - 1);
        repeat (4) @(negedge clk);
        check("R9", 64'(flag), 64'd0);
        check("R9", 64'({ol, orr}), 64'({hold_l, hold_r}));

        // R1 boundary: equal to the limit is not a violation
        strobe("R1", W'(THR), W'(-THR), 1);
        strobe("R1", W'(0), W'(-THR - 1), 1);
        // R3: release on the 512th quiet strobe
        for (int i = 0; i < HOLD; i++) strobe("R3", rnd_small(), rnd_small(), 1);
        strobe("R1", W'(THR + 1), W'(0), 1);
        // R4: retrigger in the middle of the hold
        for (int i = 0; i < 300; i++) strobe("R4", rnd_small(), rnd_small(), 1);
        strobe("R4", rnd_small(), rnd_big(), 1);
        for (int i = 0; i < HOLD; i++) strobe("R4", rnd_small(), rnd_small(), 1);
        // R2: most negative code
        strobe("R2", W'(-FULL), W'(0), 1);
        for (int i = 0; i < 20; i++) strobe("R2", rnd_small(), rnd_small(), 1);

        // R8: restart beats a violating strobe in the same cycle
        do_restart(1'b0, 1'b1, W'(-FULL));
        strobe("R8", rnd_small(), rnd_small(), 1);

        // R6: mute with filter on, random traffic incl. violations
        do_restart(1'b1, 1'b0, '0);
        for (int i = 0; i < MON + 8; i++) begin
            if ($urandom % 64 == 0) strobe("R6", rnd_big(), rnd_small(), 0);
            else strobe("R6", rnd_small(), rnd_small(), 0);
        end

        // random mix after unmute
        for (int i = 0; i < 2000; i++) begin
            if ($urandom % 200 == 0) strobe("R4", rnd_small(), rnd_big(), 1);
            else strobe("R7", rnd_small(), rnd_small(), ($urandom % 3));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule